// File: doc/BRIEF.md
# Serial Receiver Control Sequencer

This block sequences the control side of an asynchronous serial receiver. Software drives an enable bit and a sleep request. The receive datapath reports three kinds of event: a frame has begun, a frame has ended, and one of several wakeup conditions has been seen. The sequencer holds one of four states: off, armed, receiving and sleeping. It shows that state to software as a three-bit status word. It also gives the datapath an enable qualifier and a sleep qualifier.

A sleep request made while a frame is being received does not cut the frame short. The request is held and takes effect when the frame ends. A disable write always wins. It aborts any frame in progress and drops any held sleep request. The sequencer leaves the sleeping state only on a wakeup event. If a frame start arrives in the same cycle as that event, the sequencer goes straight to receiving.

Top module: `rx_seq_ctrl`

## Requirements
- R1: After reset, `stat_o` is 3'b000, and `rx_en_o` and `sleep_o` are 0.
- R2: `stat_o` is {enable, active, wakeup}. The encodings are: off 3'b000, armed 3'b100, receiving 3'b110, sleeping 3'b101. No other value appears.
- R3: A write with `en_wr_i`=1 and `en_val_i`=1 moves off to armed on the next clock. In any other state this write has no effect.
- R4: A write with `en_wr_i`=1 and `en_val_i`=0 gives 3'b000 on the next clock from any state. It takes priority over every event in the same cycle and aborts a frame in progress.
- R5: `sof_i` moves armed to receiving on the next clock. In off it has no effect. In sleeping it has no effect unless a wakeup event arrives in the same cycle.
- R6: `fdone_i` in receiving returns to armed on the next clock when no sleep request is pending.
- R7: `slp_i` in armed moves to sleeping on the next clock. In off it has no effect.
- R8: `slp_i` in receiving, or together with `sof_i` in armed, is held. The sequencer enters sleeping on the clock after `fdone_i`. A disable write drops the held request.
- R9: Any bit of `wake_i` in sleeping leads on the next clock to armed, or to receiving if `sof_i` is also high. Outside sleeping, `wake_i` has no effect.
- R10: `rx_en_o` is 1 in every state except off. `sleep_o` is 1 only in sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_val_i | input | 1 | Enable value written with en_wr_i |
| slp_i | input | 1 | Sleep request command |
| sof_i | input | 1 | Datapath: frame start detected |
| fdone_i | input | 1 | Datapath: frame completed |
| wake_i | input | N_WAKE | Datapath: wakeup conditions detected |
| stat_o | output | 3 | Status {enable, active, wakeup} |
| rx_en_o | output | 1 | Enable qualifier to datapath |
| sleep_o | output | 1 | Sleep qualifier to datapath |

## Verification
The assertions check on every cycle that only legal status encodings appear. They also check that a disable write always lands in off, that a frame start in armed and a wakeup in sleeping give the next state they must, and that the sleep qualifier is never set outside sleeping. Only the bench's scenarios show that a held sleep request survives a whole frame and is dropped by a disable. The same holds for events ignored in the wrong state and for collisions of sleep, frame start and frame end in the same cycle. These are compared against a behavioural model on every clock.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_RUN   = 2'd2,
    ST_WAKE  = 2'd3
  } rx_st_e;

  typedef struct packed {
    logic dis;
    logic ena;
    logic slp;
  } rx_cmd_t;

  localparam int unsigned STAT_W = 3;
endpackage

// File: rtl/rx_seq_cmd.sv
module rx_seq_cmd
  import rx_seq_pkg::*;
(
  input  logic    en_wr_i,
  input  logic    en_val_i,
  input  logic    slp_i,
  output rx_cmd_t cmd_o
);
  always_comb begin
    cmd_o.dis = en_wr_i & ~en_val_i;
    cmd_o.ena = en_wr_i &  en_val_i;
    cmd_o.slp = slp_i & ~cmd_o.dis;
  end
endmodule

// File: rtl/rx_seq_pend.sv
module rx_seq_pend
  import rx_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  rx_st_e  st_i,
  input  rx_cmd_t cmd_i,
  input  logic    sof_i,
  input  logic    fdone_i,
  output logic    pend_o
);
  logic pend_d, pend_q;

  always_comb begin
    pend_d = 1'b0;
    if (!cmd_i.dis) begin
      unique case (st_i)
        ST_READY: pend_d = sof_i & cmd_i.slp;            // sleep collides with start
        ST_RUN:   pend_d = ~fdone_i & (pend_q | cmd_i.slp);
        default:  pend_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rx_seq_fsm.sv
module rx_seq_fsm
  import rx_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  rx_cmd_t cmd_i,
  input  logic    pend_i,
  input  logic    sof_i,
  input  logic    fdone_i,
  input  logic    wake_i,
  output rx_st_e  st_o
);
  rx_st_e st_d, st_q;

  always_comb begin
    st_d = st_q;
    if (cmd_i.dis) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (cmd_i.ena) st_d = ST_READY;
        ST_READY: begin
          if (sof_i)          st_d = ST_RUN;
          else if (cmd_i.slp) st_d = ST_WAKE;
        end
        ST_RUN:   if (fdone_i) st_d = (pend_i | cmd_i.slp) ? ST_WAKE : ST_READY;
        ST_WAKE:  if (wake_i)  st_d = sof_i ? ST_RUN : ST_READY;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/rx_seq_ctrl.sv
module rx_seq_ctrl
  import rx_seq_pkg::*;
#(
  parameter int unsigned N_WAKE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic              slp_i,
  input  logic              sof_i,
  input  logic              fdone_i,
  input  logic [N_WAKE-1:0] wake_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              rx_en_o,
  output logic              sleep_o
);
  rx_cmd_t cmd;
  rx_st_e  st;
  logic    pend;
  logic    wake_any;
  logic [N_WAKE:0] wake_or;

  assign wake_or[0] = 1'b0;
  for (genvar g = 0; g < N_WAKE; g++) begin : g_wake
    assign wake_or[g+1] = wake_or[g] | wake_i[g];
  end
  assign wake_any = wake_or[N_WAKE];

  rx_seq_cmd u_cmd (
    .en_wr_i (en_wr_i),
    .en_val_i(en_val_i),
    .slp_i   (slp_i),
    .cmd_o   (cmd)
  );

  rx_seq_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st_i   (st),
    .cmd_i  (cmd),
    .sof_i  (sof_i),
    .fdone_i(fdone_i),
    .pend_o (pend)
  );

  rx_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .pend_i (pend),
    .sof_i  (sof_i),
    .fdone_i(fdone_i),
    .wake_i (wake_any),
    .st_o   (st)
  );

  always_comb begin
    unique case (st)
      ST_READY: stat_o = 3'b100;
      ST_RUN:   stat_o = 3'b110;
      ST_WAKE:  stat_o = 3'b101;
      default:  stat_o = 3'b000;
    endcase
  end

  assign rx_en_o = (st != ST_IDLE);
  assign sleep_o = (st == ST_WAKE);
endmodule

// File: rtl/rx_seq_ctrl_chk.sv
module rx_seq_ctrl_chk #(
  parameter int unsigned N_WAKE = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_wr_i,
  input logic              en_val_i,
  input logic              slp_i,
  input logic              sof_i,
  input logic              fdone_i,
  input logic [N_WAKE-1:0] wake_i,
  input logic [2:0]        stat_o,
  input logic              rx_en_o,
  input logic              sleep_o
);
  logic dis;
  assign dis = en_wr_i & ~en_val_i;

  // R2
  legal_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == 3'b000) || (stat_o == 3'b100) || (stat_o == 3'b110) || (stat_o == 3'b101));

  // R4
  disable_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis |=> (stat_o == 3'b000));

  // R3
  enable_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == 3'b000 && en_wr_i && en_val_i) |=> (stat_o == 3'b100));

  // R5
  sof_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == 3'b100 && sof_i && !dis) |=> (stat_o == 3'b110));

  // R6
  fdone_exits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == 3'b110 && fdone_i && !dis) |=> (stat_o == 3'b100 || stat_o == 3'b101));

  // R9
  wake_exits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == 3'b101 && (|wake_i) && !dis) |=> (stat_o[2] && !stat_o[0]));

  // R10
  sleep_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> (stat_o == 3'b101 && rx_en_o));
endmodule

bind rx_seq_ctrl rx_seq_ctrl_chk #(.N_WAKE(N_WAKE)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_wr_i (en_wr_i),
  .en_val_i(en_val_i),
  .slp_i   (slp_i),
  .sof_i   (sof_i),
  .fdone_i (fdone_i),
  .wake_i  (wake_i),
  .stat_o  (stat_o),
  .rx_en_o (rx_en_o),
  .sleep_o (sleep_o)
);

// File: tb/rx_seq_ctrl_tb_top.sv
module rx_seq_ctrl_tb_top;
  localparam int unsigned N_WAKE = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_wr = 0, en_val = 0, slp = 0, sof = 0, fdone = 0;
  logic [N_WAKE-1:0] wake = '0;
  logic [2:0] stat;
  logic rx_en, sleep;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model: 0 off, 1 armed, 2 receiving, 3 sleeping
  int m_st = 0;
  int m_pend = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_seq_ctrl #(.N_WAKE(N_WAKE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_wr_i(en_wr), .en_val_i(en_val),
    .slp_i(slp), .sof_i(sof), .fdone_i(fdone), .wake_i(wake),
    .stat_o(stat), .rx_en_o(rx_en), .sleep_o(sleep)
  );

  function automatic logic [2:0] enc(int s);
    case (s)
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_pend = 0;
    end else if (en_wr && !en_val) begin
      m_st = 0; m_pend = 0;
    end else begin
      int nst, np;
      nst = m_st; np = 0;
      if (m_st == 0 && en_wr && en_val) nst = 1;
      else if (m_st == 1) begin
        if (sof) begin nst = 2; np = slp ? 1 : 0; end
        else if (slp) nst = 3;
      end else if (m_st == 2) begin
        if (fdone) nst = (m_pend != 0 || slp) ? 3 : 1;
        else np = (m_pend != 0 || slp) ? 1 : 0;
      end else if (m_st == 3 && wake != 0) nst = sof ? 2 : 1;
      m_st = nst; m_pend = np;
    end
  end

  // R2 R10: compare every clock
  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (stat !== enc(m_st) || rx_en !== (m_st != 0) || sleep !== (m_st == 3)) begin
        errors++;
        $display("FAIL R2/R10 model: stat=%b rx_en=%b sleep=%b exp stat=%b rx_en=%b sleep=%b",
                 stat, rx_en, sleep, enc(m_st), m_st != 0, m_st == 3);
      end
    end
  end

  task automatic step(bit w, bit v, bit s, bit f, bit d, logic [N_WAKE-1:0] k);
    en_wr = w; en_val = v; slp = s; sof = f; fdone = d; wake = k;
    @(negedge clk);
    en_wr = 0; en_val = 0; slp = 0; sof = 0; fdone = 0; wake = '0;
  endtask

  task automatic expect_st(logic [2:0] e, string tag);
    checks++;
    if (stat !== e) begin
      errors++;
      $display("FAIL %s: stat=%b exp=%b", tag, stat, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (stat !== 3'b000 || rx_en !== 0 || sleep !== 0) begin
      errors++;
      $display("FAIL R1: stat=%b rx_en=%b sleep=%b exp 000 0 0", stat, rx_en, sleep);
    end
    rst_ni = 1;
    @(negedge clk);
    expect_st(3'b000, "R1");
    step(0,0,0,1,0,'0); expect_st(3'b000, "R5 sof in off");
    step(0,0,1,0,0,'0); expect_st(3'b000, "R7 sleep in off");
    step(0,0,0,0,0,2'b01); expect_st(3'b000, "R9 wake in off");
    step(1,1,0,0,0,'0); expect_st(3'b100, "R3 enable");
    step(1,1,0,0,0,'0); expect_st(3'b100, "R3 re-enable");
    step(0,0,0,0,0,2'b10); expect_st(3'b100, "R9 wake in armed");
    step(0,0,0,1,0,'0); expect_st(3'b110, "R5 start");
    step(1,1,0,0,0,'0); expect_st(3'b110, "R3 enable in run");
    step(0,0,0,0,1,'0); expect_st(3'b100, "R6 frame done");
    step(0,0,1,0,0,'0); expect_st(3'b101, "R7 sleep");
    step(0,0,0,1,0,'0); expect_st(3'b101, "R5 sof in sleep");
    step(0,0,0,0,0,2'b10); expect_st(3'b100, "R9 wake1");
    step(0,0,1,0,0,'0); expect_st(3'b101, "R7 sleep again");
    step(0,0,0,1,0,2'b01); expect_st(3'b110, "R9 wake0 with sof");
    step(0,0,1,0,0,'0); expect_st(3'b110, "R8 sleep deferred");
    step(0,0,0,0,0,'0); expect_st(3'b110, "R8 still receiving");
    step(0,0,0,0,1,'0); expect_st(3'b101, "R8 sleep after frame");
    step(1,0,0,0,0,2'b11); expect_st(3'b000, "R4 disable over wake");
    step(1,1,0,0,0,'0); step(0,0,0,1,0,'0);
    step(1,0,0,0,1,'0); expect_st(3'b000, "R4 abort frame");
    step(1,1,0,0,0,'0); step(0,0,0,1,0,'0); step(0,0,1,0,0,'0);
    step(1,0,0,0,0,'0); expect_st(3'b000, "R4 disable with held sleep");
    step(1,1,0,0,0,'0); step(0,0,0,1,0,'0);
    step(0,0,0,0,1,'0); expect_st(3'b100, "R8 held sleep dropped");
    step(0,0,1,1,0,'0); expect_st(3'b110, "R8 sleep with start");
    step(0,0,0,0,1,'0); expect_st(3'b101, "R8 collision sleep");
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step((r % 23) == 0, ((r >> 8) % 4) != 0, ((r >> 12) % 9) == 0,
           ((r >> 16) % 5) == 0, ((r >> 20) % 6) == 0,
           (((r >> 24) % 7) == 0) ? 2'(r >> 28) : '0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule